// File: doc/BRIEF.md
# CAN Node Control and Interrupt Logic

This block holds the control and status registers of a single CAN node. It sits between a simple register bus (write strobe, address, write data, combinational read data) and a CAN protocol engine. The engine is seen only through status inputs: a last-error-code update strobe with its 3-bit value, the bus-off and error-warning levels, a bus-idle level, and single-cycle list-length and list-object error strobes. Bit framing, arbitration and the error counters belong to the engine and are not part of this block.

The block keeps the node's enable and mode bits and turns protocol events into two kinds of interrupt. The first is a last-error-code interrupt. The second is an alert interrupt, which merges several event sources into one. Each kind is steered by a pointer field to one of `NUM_LINES` interrupt outputs. A state machine with three states controls initialisation and a graceful disable:

- `NODE_INIT`: the node is halted.
- `NODE_ACTIVE`: the node is on the bus.
- `NODE_DRAIN`: a disable has been requested and the node waits for bus-idle or bus-off.

The transitions are named as follows:

- `INIT->ACTIVE`: software writes the control register with the init bit at 0.
- `ACTIVE->INIT`: software writes the init bit at 1.
- `ACTIVE->DRAIN`: the disable bit is set.
- `DRAIN->INIT`: the hardware sets init once the bus is idle or the node is bus-off. This has priority over the two transitions below.
- `DRAIN->INIT`: software writes the init bit at 1.
- `DRAIN->ACTIVE`: the disable bit has been cleared, which aborts the drain.

The block also write-protects three configuration registers behind an enable bit. It also provides a listen-only analyze mode, which forces the transmit line recessive and suppresses acknowledge.

Register map (address: contents):

- 0, control: bit0 init, bit2 LEC interrupt enable, bit3 alert enable, bit4 disable, bit6 configuration-change enable, bit7 analyze.
- 1, status: bits[2:0] last error code, bit4 error-warning, bit5 bus-off, bit6 list-length flag, bit7 list-object flag.
- 2, pointers: bits[1:0] LEC line, bits[3:2] alert line.
- 3, bit timing.
- 4, port control.
- 5, error counter.

Top module: `can_node_ctrl`

## Requirements
- R1: After synchronous reset, `node_init` is 1. The control register reads 0x0001, the status flags and the pointers read 0, the three configuration registers read 0, and no interrupt line is high.
- R2: A `lec_upd` strobe always loads `lec_val` into status bits[2:0]. When the value is non-zero and control bit2 is 1, the line chosen by pointer bits[1:0] goes high for exactly one clock, in the cycle after the strobe. A zero value, or control bit2 at 0, gives no pulse.
- R3: When control bit3 is 1, any change of `bus_off` or `err_warn` from its value on the previous clock pulses the line chosen by pointer bits[3:2] for one clock, in the cycle after the change. Rising and falling edges both count.
- R4: A `list_len_err` strobe sets status bit6 and a `list_obj_err` strobe sets status bit7. Both flags stay set. Either strobe also raises an alert pulse when control bit3 is 1.
- R5: Writing 0 to status bit6 or bit7 clears that flag, and writing 1 leaves it unchanged. A new error in the same cycle as a clearing write keeps the flag set.
- R6: Once the disable bit (control bit4) is set while the node is active, the node enters the drain state on the next clock and stays there until `bus_idle` or `bus_off` is 1. On that clock `node_init` becomes 1, and if control bit3 is 1 an alert pulse appears in the same cycle.
- R7: When software sets init by writing control bit0 as 1, no alert is raised. Clearing the disable bit while draining returns the node to active.
- R8: When control bit6 is 0, writes to addresses 3, 4 and 5 are ignored and the old values stay readable. When control bit6 is 1, those addresses take the written data.
- R9: A write to control bit7 (analyze) changes it only if `node_init` is 1 in the cycle of the write. Otherwise the bit keeps its value.
- R10: While analyze is 1, `can_tx` is 1 whatever `eng_tx` is, and `ack_drive` is 0. While analyze is 0, `can_tx` follows `eng_tx` and `ack_drive` follows `eng_ack`.
- R11: When a LEC event and an alert event occur in the same cycle, both selected lines pulse together. If both pointers select the same line, that one line pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both write and read |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| lec_upd | input | 1 | Last-error-code update strobe from the engine |
| lec_val | input | 3 | Last-error-code value |
| bus_off | input | 1 | Bus-off level from the engine |
| err_warn | input | 1 | Error-warning level from the engine |
| bus_idle | input | 1 | Bus-idle level from the engine |
| list_len_err | input | 1 | List length error strobe |
| list_obj_err | input | 1 | List object error strobe |
| eng_tx | input | 1 | Transmit bit from the engine |
| eng_ack | input | 1 | Acknowledge request from the engine |
| node_init | output | 1 | Node is in the initialisation state |
| can_tx | output | 1 | Gated transmit line |
| ack_drive | output | 1 | Gated acknowledge request |
| irq_line | output | NUM_LINES | Interrupt outputs, one-clock pulses |

## Verification
The bench goes after the drain exit that coincides with a bus-off rise. Here two alert causes merge into one pulse. A design that counted them separately, or took the exit one cycle late, would show a missing or shifted pulse. It clears a list flag in the same cycle that the error fires again. A design that gave the clear priority would drop the flag. It writes the analyze bit on the very write that leaves init, and again while active. A design that looked at the new init value would either refuse the first write or accept the second. It also drives a falling bus-off edge, a zero-valued error code, and both pointers aimed at one line. These catch a design that detects only rising edges, treats every update as an error, or routes pointers incorrectly.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;

    // register addresses
    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 1;
    localparam int PTR_ADDR  = 2;
    localparam int CFG_BASE  = 3;   // bit timing, port control, error counter follow
    localparam int NUM_CFG   = 3;

    // control register bit positions
    localparam int B_INIT  = 0;
    localparam int B_LECIE = 2;
    localparam int B_ALIE  = 3;
    localparam int B_DIS   = 4;
    localparam int B_CCE   = 6;
    localparam int B_CALM  = 7;

    // status register bit positions
    localparam int B_EWRN  = 4;
    localparam int B_BOFF  = 5;
    localparam int B_LLE   = 6;
    localparam int B_LOE   = 7;

    typedef enum logic [1:0] {
        NODE_INIT   = 2'd0,
        NODE_ACTIVE = 2'd1,
        NODE_DRAIN  = 2'd2
    } node_state_e;

    typedef struct packed {
        logic calm;
        logic cce;
        logic candis;
        logic alie;
        logic lecie;
    } node_ctrl_t;

endpackage

// File: rtl/node_ctrl_fsm.sv
module node_ctrl_fsm
    import can_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       bus_idle,
    input  logic       bus_off,
    output logic       node_init,
    output logic       hw_init_set,
    output node_ctrl_t ctrl
);

    node_state_e state_q, state_d;
    logic        drain_done;

    assign drain_done = bus_idle || bus_off;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= NODE_INIT;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NODE_INIT: begin
                if (ctrl_wr && !ctrl_wdata[B_INIT]) state_d = NODE_ACTIVE;
            end
            NODE_ACTIVE: begin
                if (ctrl_wr && ctrl_wdata[B_INIT]) state_d = NODE_INIT;
                else if (ctrl.candis)              state_d = NODE_DRAIN;
            end
            NODE_DRAIN: begin
                if (drain_done)                         state_d = NODE_INIT;
                else if (ctrl_wr && ctrl_wdata[B_INIT]) state_d = NODE_INIT;
                else if (!ctrl.candis)                  state_d = NODE_ACTIVE;
            end
            default: state_d = NODE_INIT;
        endcase
    end

    // outputs
    always_comb begin
        node_init   = 1'b0;
        hw_init_set = 1'b0;
        unique case (state_q)
            NODE_INIT:   node_init = 1'b1;
            NODE_ACTIVE: node_init = 1'b0;
            NODE_DRAIN:  hw_init_set = drain_done;
            default:     node_init = 1'b1;
        endcase
    end

    // control bits
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.lecie  <= ctrl_wdata[B_LECIE];
            ctrl.alie   <= ctrl_wdata[B_ALIE];
            ctrl.candis <= ctrl_wdata[B_DIS];
            ctrl.cce    <= ctrl_wdata[B_CCE];
            if (node_init) ctrl.calm <= ctrl_wdata[B_CALM];
        end
    end

    assert_calm_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !node_init |=> $stable(ctrl.calm));

    assert_drain_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == NODE_DRAIN && drain_done) |=> node_init);

    assert_drain_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == NODE_ACTIVE && ctrl.candis && !ctrl_wr) |=> (state_q == NODE_DRAIN));

endmodule

// File: rtl/node_irq_route.sv
module node_irq_route #(
    parameter int NUM_LINES = 4,
    parameter int PTR_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lecie,
    input  logic                 alie,
    input  logic                 lec_upd,
    input  logic [2:0]           lec_val,
    input  logic                 bus_off,
    input  logic                 err_warn,
    input  logic                 lle_set,
    input  logic                 loe_set,
    input  logic                 hw_init_set,
    input  logic [PTR_W-1:0]     lec_ptr,
    input  logic [PTR_W-1:0]     alert_ptr,
    output logic [NUM_LINES-1:0] irq_line
);

    logic                 boff_q, ewrn_q;
    logic                 lec_ev, alert_ev, status_chg;
    logic [NUM_LINES-1:0] irq_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            boff_q <= 1'b0;
            ewrn_q <= 1'b0;
        end else begin
            boff_q <= bus_off;
            ewrn_q <= err_warn;
        end
    end

    assign status_chg = (bus_off ^ boff_q) | (err_warn ^ ewrn_q);
    assign lec_ev     = lecie && lec_upd && (lec_val != 3'd0);
    assign alert_ev   = alie && (status_chg || lle_set || loe_set || hw_init_set);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign irq_d[g] = (lec_ev   && (lec_ptr   == PTR_W'(g))) ||
                          (alert_ev && (alert_ptr == PTR_W'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) irq_line <= '0;
        else     irq_line <= irq_d;
    end

    assert_lec_route_R2: assert property (@(posedge clk) disable iff (rst)
        (lecie && lec_upd && lec_val != 3'd0) |=> irq_line[$past(lec_ptr)]);

    assert_lec_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!alie && !(lec_upd && lecie)) |=> (irq_line == '0));

    assert_alert_hwinit_R6: assert property (@(posedge clk) disable iff (rst)
        (alie && hw_init_set) |=> irq_line[$past(alert_ptr)]);

endmodule

// File: rtl/node_reg_bank.sv
module node_reg_bank
    import can_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           stat_wr,
    input  logic                           ptr_wr,
    input  logic [NUM_CFG-1:0]             cfg_wr,
    input  logic                           cce,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           lec_upd,
    input  logic [2:0]                     lec_val,
    input  logic                           lle_in,
    input  logic                           loe_in,
    output logic [2:0]                     lec_q,
    output logic                           lle,
    output logic                           loe,
    output logic [PTR_W-1:0]               lec_ptr,
    output logic [PTR_W-1:0]               alert_ptr,
    output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q
);

    // last error code field
    always_ff @(posedge clk) begin
        if (rst)          lec_q <= 3'd0;
        else if (lec_upd) lec_q <= lec_val;
    end

    // sticky list flags: set wins over a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            lle <= 1'b0;
            loe <= 1'b0;
        end else begin
            if (lle_in)                        lle <= 1'b1;
            else if (stat_wr && !wr_data[B_LLE]) lle <= 1'b0;
            if (loe_in)                        loe <= 1'b1;
            else if (stat_wr && !wr_data[B_LOE]) loe <= 1'b0;
        end
    end

    // interrupt pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            lec_ptr   <= '0;
            alert_ptr <= '0;
        end else if (ptr_wr) begin
            lec_ptr   <= wr_data[PTR_W-1:0];
            alert_ptr <= wr_data[2*PTR_W-1:PTR_W];
        end
    end

    // write-protected configuration registers
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)                 cfg_q[g] <= '0;
            else if (cfg_wr[g] && cce) cfg_q[g] <= wr_data;
        end
    end

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cce |=> $stable(cfg_q));

    assert_lle_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        lle_in |=> lle);

    assert_loe_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (loe && !stat_wr) |=> loe);

endmodule

// File: rtl/can_node_ctrl.sv
module can_node_ctrl
    import can_ctrl_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 3,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 lec_upd,
    input  logic [2:0]           lec_val,
    input  logic                 bus_off,
    input  logic                 err_warn,
    input  logic                 bus_idle,
    input  logic                 list_len_err,
    input  logic                 list_obj_err,
    input  logic                 eng_tx,
    input  logic                 eng_ack,
    output logic                 node_init,
    output logic                 can_tx,
    output logic                 ack_drive,
    output logic [NUM_LINES-1:0] irq_line
);

    localparam int PTR_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    node_ctrl_t                     ctrl;
    logic                           hw_init_set;
    logic                           ctrl_wr, stat_wr, ptr_wr;
    logic [NUM_CFG-1:0]             cfg_wr;
    logic [2:0]                     lec_q;
    logic                           lle, loe;
    logic [PTR_W-1:0]               lec_ptr, alert_ptr;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;

    // address decode
    assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign stat_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));
    assign ptr_wr  = wr_en && (addr == ADDR_W'(PTR_ADDR));
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_dec
        assign cfg_wr[g] = wr_en && (addr == ADDR_W'(CFG_BASE + g));
    end

    node_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (wr_data[7:0]),
        .bus_idle    (bus_idle),
        .bus_off     (bus_off),
        .node_init   (node_init),
        .hw_init_set (hw_init_set),
        .ctrl        (ctrl)
    );

    node_reg_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .stat_wr   (stat_wr),
        .ptr_wr    (ptr_wr),
        .cfg_wr    (cfg_wr),
        .cce       (ctrl.cce),
        .wr_data   (wr_data),
        .lec_upd   (lec_upd),
        .lec_val   (lec_val),
        .lle_in    (list_len_err),
        .loe_in    (list_obj_err),
        .lec_q     (lec_q),
        .lle       (lle),
        .loe       (loe),
        .lec_ptr   (lec_ptr),
        .alert_ptr (alert_ptr),
        .cfg_q     (cfg_q)
    );

    node_irq_route #(.NUM_LINES(NUM_LINES), .PTR_W(PTR_W)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .lecie       (ctrl.lecie),
        .alie        (ctrl.alie),
        .lec_upd     (lec_upd),
        .lec_val     (lec_val),
        .bus_off     (bus_off),
        .err_warn    (err_warn),
        .lle_set     (list_len_err),
        .loe_set     (list_obj_err),
        .hw_init_set (hw_init_set),
        .lec_ptr     (lec_ptr),
        .alert_ptr   (alert_ptr),
        .irq_line    (irq_line)
    );

    // analyze-mode gating
    assign can_tx    = ctrl.calm ? 1'b1 : eng_tx;
    assign ack_drive = eng_ack && !ctrl.calm;

    // read mux
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data[B_INIT]  = node_init;
            rd_data[B_LECIE] = ctrl.lecie;
            rd_data[B_ALIE]  = ctrl.alie;
            rd_data[B_DIS]   = ctrl.candis;
            rd_data[B_CCE]   = ctrl.cce;
            rd_data[B_CALM]  = ctrl.calm;
        end else if (addr == ADDR_W'(STAT_ADDR)) begin
            rd_data[2:0]    = lec_q;
            rd_data[B_EWRN] = err_warn;
            rd_data[B_BOFF] = bus_off;
            rd_data[B_LLE]  = lle;
            rd_data[B_LOE]  = loe;
        end else if (addr == ADDR_W'(PTR_ADDR)) begin
            rd_data[2*PTR_W-1:0] = {alert_ptr, lec_ptr};
        end else begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (addr == ADDR_W'(CFG_BASE + i)) rd_data = cfg_q[i];
            end
        end
    end

    assert_irq_reset_R1: assert property (@(posedge clk)
        rst |=> (irq_line == '0 && node_init));

endmodule

// File: tb/test_can_node_ctrl.sv
module test_can_node_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        lec_upd;
    logic [2:0]  lec_val;
    logic        bus_off, err_warn, bus_idle, list_len_err, list_obj_err;
    logic        eng_tx, eng_ack;
    logic        node_init, can_tx, ack_drive;
    logic [3:0]  irq_line;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    can_node_ctrl i_can_node_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .lec_upd(lec_upd), .lec_val(lec_val),
        .bus_off(bus_off), .err_warn(err_warn), .bus_idle(bus_idle),
        .list_len_err(list_len_err), .list_obj_err(list_obj_err),
        .eng_tx(eng_tx), .eng_ack(eng_ack), .node_init(node_init),
        .can_tx(can_tx), .ack_drive(ack_drive), .irq_line(irq_line)
    );

    // behavioural reference state
    int m_st;            // 0 init, 1 active, 2 draining
    bit m_lecie, m_alie, m_dis, m_cce, m_calm;
    int m_lec, m_lptr, m_aptr;
    bit m_lle, m_loe, m_boffq, m_ewrnq;
    int m_cfg[3];
    int m_irq;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd();
        int v = 0;
        case (addr)
            3'd0: v = int'(m_st == 0) | (int'(m_lecie) << 2) | (int'(m_alie) << 3) |
                      (int'(m_dis) << 4) | (int'(m_cce) << 6) | (int'(m_calm) << 7);
            3'd1: v = m_lec | (int'(err_warn) << 4) | (int'(bus_off) << 5) |
                      (int'(m_lle) << 6) | (int'(m_loe) << 7);
            3'd2: v = m_lptr | (m_aptr << 2);
            3'd3: v = m_cfg[0];
            3'd4: v = m_cfg[1];
            3'd5: v = m_cfg[2];
            default: v = 0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_lecie = 0; m_alie = 0; m_dis = 0; m_cce = 0; m_calm = 0;
            m_lec = 0; m_lptr = 0; m_aptr = 0; m_lle = 0; m_loe = 0;
            m_boffq = 0; m_ewrnq = 0; m_irq = 0;
            foreach (m_cfg[i]) m_cfg[i] = 0;
        end else begin
            bit hw, lec_ev, al_ev, cw;
            int ns, nirq;
            cw = wr_en && addr == 3'd0;
            hw = (m_st == 2) && (bus_idle || bus_off);
            lec_ev = m_lecie && lec_upd && lec_val != 3'd0;
            al_ev = m_alie && ((bus_off != m_boffq) || (err_warn != m_ewrnq) ||
                               list_len_err || list_obj_err || hw);
            nirq = 0;
            if (lec_ev) nirq |= (1 << m_lptr);
            if (al_ev)  nirq |= (1 << m_aptr);
            ns = m_st;
            if (m_st == 0) begin
                if (cw && !wr_data[0]) ns = 1;
            end else if (m_st == 1) begin
                if (cw && wr_data[0]) ns = 0;
                else if (m_dis) ns = 2;
            end else begin
                if (bus_idle || bus_off) ns = 0;
                else if (cw && wr_data[0]) ns = 0;
                else if (!m_dis) ns = 1;
            end
            if (wr_en && addr >= 3'd3 && addr <= 3'd5 && m_cce) m_cfg[addr - 3] = int'(wr_data);
            if (cw) begin
                if (m_st == 0) m_calm = wr_data[7];
                m_lecie = wr_data[2]; m_alie = wr_data[3];
                m_dis = wr_data[4];   m_cce = wr_data[6];
            end
            if (wr_en && addr == 3'd2) begin
                m_lptr = int'(wr_data[1:0]);
                m_aptr = int'(wr_data[3:2]);
            end
            if (lec_upd) m_lec = int'(lec_val);
            if (list_len_err) m_lle = 1;
            else if (wr_en && addr == 3'd1 && !wr_data[6]) m_lle = 0;
            if (list_obj_err) m_loe = 1;
            else if (wr_en && addr == 3'd1 && !wr_data[7]) m_loe = 0;
            m_boffq = bus_off; m_ewrnq = err_warn;
            m_irq = nirq;
            m_st = ns;
        end
    end

    // per-cycle comparison, sampled well after the edge
    always @(posedge clk) begin
        #3;
        if (running) begin
            check("R2 R3 R4 R6 R11 irq_line", int'(irq_line), m_irq);
            check("R1 R6 R7 node_init", int'(node_init), int'(m_st == 0));
            check("R10 can_tx", int'(can_tx), m_calm ? 1 : int'(eng_tx));
            check("R10 ack_drive", int'(ack_drive), int'(eng_ack && !m_calm));
            check("R1 R5 R8 R9 rd_data", int'(rd_data), exp_rd());
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, int a, int exp);
        @(negedge clk);
        addr = 3'(a);
        #1 check(tag, int'(rd_data), exp);
    endtask

    task automatic lec_pulse(int v);
        @(negedge clk);
        lec_upd = 1'b1; lec_val = 3'(v);
        @(negedge clk);
        lec_upd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; addr = 0; wr_data = 0; lec_upd = 0; lec_val = 0;
        bus_off = 0; err_warn = 0; bus_idle = 0; list_len_err = 0; list_obj_err = 0;
        eng_tx = 0; eng_ack = 1;
        idle(3);
        rst = 1'b0;
        running = 1'b1;
        rd_check("R1 reset control", 0, 16'h0001);
        rd_check("R1 reset status", 1, 0);

        // R11 pointers: LEC to line 2, alert to line 1
        bus_wr(2, 16'h0006);
        // R2 disabled enable, then enabled, then zero code
        lec_pulse(3);
        bus_wr(0, 16'h0005);
        lec_pulse(5);
        idle(1);
        lec_pulse(0);
        rd_check("R2 zero code loaded", 1, 0);

        // R3 status edges with alert enabled
        bus_wr(0, 16'h000D);
        @(negedge clk) bus_off = 1;
        idle(2);
        @(negedge clk) bus_off = 0;
        idle(2);
        @(negedge clk) err_warn = 1;
        idle(2);
        @(negedge clk) err_warn = 0;
        idle(2);

        // R4 list errors and R5 clear rules
        @(negedge clk) list_len_err = 1;
        @(negedge clk) list_len_err = 0; list_obj_err = 1;
        @(negedge clk) list_obj_err = 0;
        rd_check("R4 both flags set", 1, 16'h00C0);
        bus_wr(1, 16'h00C0);
        rd_check("R5 write one keeps flags", 1, 16'h00C0);
        @(negedge clk) begin
            wr_en = 1; addr = 3'd1; wr_data = 16'h0000; list_len_err = 1;
        end
        @(negedge clk) begin
            wr_en = 0; list_len_err = 0;
        end
        rd_check("R5 set wins over clear", 1, 16'h0040);
        bus_wr(1, 16'h0000);
        rd_check("R5 flags cleared", 1, 0);

        // R8 configuration guard
        bus_wr(3, 16'hBEEF);
        rd_check("R8 guarded write ignored", 3, 0);
        bus_wr(0, 16'h004D);
        bus_wr(3, 16'h1234);
        bus_wr(4, 16'h00A5);
        bus_wr(5, 16'h0077);
        rd_check("R8 timing written", 3, 16'h1234);
        bus_wr(0, 16'h000D);
        bus_wr(4, 16'hFFFF);
        rd_check("R8 port control held", 4, 16'h00A5);

        // R9/R10 analyze mode
        bus_wr(0, 16'h008D);
        @(negedge clk) begin eng_tx = 0; eng_ack = 1; end
        #1 check("R10 tx recessive", int'(can_tx), 1);
        bus_wr(0, 16'h008C);             // leaves init, calm accepted (init was 1)
        bus_wr(0, 16'h000C);             // active: calm must stay
        rd_check("R9 calm locked while active", 0, 16'h008C);
        bus_wr(0, 16'h000D);             // back to init by software, no alert (R7)
        bus_wr(0, 16'h000D);             // now calm clears
        @(negedge clk) eng_tx = 0;
        #1 check("R10 tx follows engine", int'(can_tx), 0);

        // R6 drain to bus idle with alert
        bus_wr(0, 16'h001C);
        idle(5);
        @(negedge clk) bus_idle = 1;
        @(negedge clk) bus_idle = 0;
        idle(2);
        bus_wr(0, 16'h000D);
        // R7 software init and drain abort
        bus_wr(0, 16'h000C);
        idle(2);
        bus_wr(0, 16'h000D);
        idle(2);
        bus_wr(0, 16'h001C);
        idle(3);
        bus_wr(0, 16'h000C);
        idle(3);
        // R6 drain exit through bus-off, merged with status change, R11 same line
        bus_wr(2, 16'h0000);
        bus_wr(0, 16'h001C);
        idle(3);
        @(negedge clk) begin bus_off = 1; lec_upd = 1; lec_val = 3'd6; end
        @(negedge clk) lec_upd = 0;
        idle(2);
        @(negedge clk) bus_off = 0;
        bus_wr(0, 16'h000D);
        // R11 different lines in one cycle
        bus_wr(2, 16'h000D);             // LEC line 1, alert line 3
        @(negedge clk) begin lec_upd = 1; lec_val = 3'd2; list_obj_err = 1; end
        @(negedge clk) begin lec_upd = 0; list_obj_err = 0; end
        idle(3);

        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule